// File: doc/BRIEF.md
# Serial Device Register Interface

This block is the host-facing register set of a byte-oriented serial device. A host reaches it through a small bus with a 2-bit register select, separate read and write strobes, and one data byte in each direction. Behind the bus sit two byte queues. The transmit queue is filled by host writes and drained by the line logic. The receive queue is filled by the line logic and drained by host reads. The line logic also pulses strobes when a transmit underrun or a receive overrun happens.

The four status bits clear in two different ways. The two buffer flags follow queue occupancy, so they change as a side effect of data-port traffic. The two error flags are sticky. Only a write-one-to-clear through the action register removes them. Serialisation, baud timing and interrupt generation belong to neighbouring blocks.

Register map (select value: register): 0 status (read-only), 1 action (write-only), 2 transmit data (write-only), 3 receive data (read-only). Status and action bit positions: bit 0 transmit space, bit 1 receive data present, bit 2 underrun, bit 3 overrun. Upper bits read as zero.

Top module: `serdev_hostregs`

## Requirements
- R1: Status bit 0 (select 0) is 1 exactly when the transmit queue is not full. A transmit-data write that fills the queue makes it read 0 from the next cycle.
- R2: Status bit 1 is 1 exactly when the receive queue holds at least one byte. A receive-data read that takes the last byte makes it read 0 from the next cycle.
- R3: Writes to select 2 enqueue bytes that the line side sees on its output in write order. The line side removes a byte by pulsing its take strobe. A write while the queue is full is discarded.
- R4: A read of select 3 returns the oldest received byte, and the byte is removed at that clock edge. A read of an empty receive queue returns 0 and changes nothing.
- R5: Status bits 2 and 3 stay set until the host writes 1 to the same bit of the action register (select 1). Writing 0 to either bit leaves it unchanged.
- R6: When a setting event and a clearing action write reach the same error bit in the same cycle, the bit ends up set.
- R7: A received byte that arrives while the receive queue is full is dropped and sets status bit 3. The line overrun strobe also sets bit 3, and the line underrun strobe sets bit 2.
- R8: Reads of select 1 or 2 return 0. Writes to select 0 or 3 change neither the status nor the queues.
- R9: Action bits 0 and 1 have no effect. The buffer flags follow queue occupancy only.
- R10: After reset both queues are empty, the error bits are clear, and the status register reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of bus_rd, 0 otherwise |
| line_tx_byte | output | DATA_W | Oldest byte waiting in the transmit queue |
| line_tx_valid | output | 1 | Transmit queue holds a byte |
| line_tx_take | input | 1 | Line side removes the presented transmit byte |
| line_rx_byte | input | DATA_W | Received byte from the line |
| line_rx_strobe | input | 1 | line_rx_byte is valid this cycle |
| line_urun_evt | input | 1 | Transmit underrun event pulse |
| line_ovrun_evt | input | 1 | Receive overrun event pulse |

## Verification
The bench fills each queue one entry past its depth and reads status after every step. A design with an off-by-one in the space flag, or one that accepts the extra byte, would show a wrong bit 0, a wrong count, or a corrupted drain order. All sixteen action values are swept over set error flags. This exposes designs where writing 0 clears a flag, where the clear mask is misaligned, or where action bits 0 and 1 flush a queue. Event-versus-clear collisions, reads of write-only registers, writes to read-only registers and reads of an empty receive queue are also covered. A design that lets the clear win, returns stale data, or pops or pushes on the wrong select would give a wrong status or a wrong data byte.

// File: rtl/serdev_pkg.sv
package serdev_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ACTION = 2'd1,
    SEL_TXDATA = 2'd2,
    SEL_RXDATA = 2'd3
  } reg_sel_e;

  localparam int unsigned STB_TXSPACE = 0;
  localparam int unsigned STB_RXDATA  = 1;
  localparam int unsigned STB_URUN    = 2;
  localparam int unsigned STB_OVRUN   = 3;
  localparam int unsigned STATUS_W    = 4;

  // Assemble the status nibble from its four conditions.
  function automatic logic [STATUS_W-1:0] pack_status(input logic tx_space,
                                                      input logic rx_data,
                                                      input logic urun,
                                                      input logic ovrun);
    logic [STATUS_W-1:0] s;
    s = '0;
    s[STB_TXSPACE] = tx_space;
    s[STB_RXDATA]  = rx_data;
    s[STB_URUN]    = urun;
    s[STB_OVRUN]   = ovrun;
    return s;
  endfunction

  // Sticky flag next state: a set event outranks a clear request.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [W-1:0]                   push_data,
  input  logic                           pop,
  output logic [W-1:0]                   head,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty,
  output logic                           push_ok,
  output logic                           pop_ok
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count_q;

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = empty ? '0 : mem[rd_ptr];
  assign count   = count_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_step(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_step(rd_ptr);
      count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count_q));

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count_q == '0));

endmodule

// File: rtl/sticky_flags.sv
module sticky_flags
  import serdev_pkg::*;
#(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag[i] <= 1'b0;
      else        flag[i] <= sticky_next(flag[i], set[i], clr[i]);
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag[i]);

    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr[i]) |=> flag[i]);

    assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flag[i]);
  end

endmodule

// File: rtl/serdev_hostregs.sv
module serdev_hostregs
  import serdev_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TXQ_DEPTH = 4,
  parameter int unsigned RXQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] line_tx_byte,
  output logic              line_tx_valid,
  input  logic              line_tx_take,
  input  logic [DATA_W-1:0] line_rx_byte,
  input  logic              line_rx_strobe,
  input  logic              line_urun_evt,
  input  logic              line_ovrun_evt
);
  localparam int unsigned TCW = $clog2(TXQ_DEPTH+1);
  localparam int unsigned RCW = $clog2(RXQ_DEPTH+1);

  // Named decode events
  logic wr_txd, rd_rxd, wr_act;
  assign wr_txd = bus_wr & (bus_sel == SEL_TXDATA);
  assign rd_rxd = bus_rd & (bus_sel == SEL_RXDATA);
  assign wr_act = bus_wr & (bus_sel == SEL_ACTION);

  // Transmit queue
  logic [TCW-1:0] tx_count;
  logic tx_full, tx_empty, tx_push_ok, tx_pop_ok;

  byte_queue #(.W(DATA_W), .DEPTH(TXQ_DEPTH)) u_txq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wr_txd),
    .push_data(bus_wdata),
    .pop      (line_tx_take),
    .head     (line_tx_byte),
    .count    (tx_count),
    .full     (tx_full),
    .empty    (tx_empty),
    .push_ok  (tx_push_ok),
    .pop_ok   (tx_pop_ok)
  );
  assign line_tx_valid = ~tx_empty;

  // Receive queue
  logic [DATA_W-1:0] rx_head;
  logic [RCW-1:0] rx_count;
  logic rx_full, rx_empty, rx_push_ok, rx_pop_ok;

  byte_queue #(.W(DATA_W), .DEPTH(RXQ_DEPTH)) u_rxq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (line_rx_strobe),
    .push_data(line_rx_byte),
    .pop      (rd_rxd),
    .head     (rx_head),
    .count    (rx_count),
    .full     (rx_full),
    .empty    (rx_empty),
    .push_ok  (rx_push_ok),
    .pop_ok   (rx_pop_ok)
  );

  // Error flags: index 0 underrun, index 1 overrun
  logic rx_drop;
  logic [1:0] err_set, err_clr, err_flag;
  assign rx_drop    = line_rx_strobe & ~rx_push_ok;
  assign err_set[0] = line_urun_evt;
  assign err_set[1] = line_ovrun_evt | rx_drop;
  assign err_clr[0] = wr_act & bus_wdata[STB_URUN];
  assign err_clr[1] = wr_act & bus_wdata[STB_OVRUN];

  sticky_flags #(.N(2)) u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (err_set),
    .clr  (err_clr),
    .flag (err_flag)
  );

  logic [STATUS_W-1:0] status;
  assign status = pack_status(~tx_full, ~rx_empty, err_flag[0], err_flag[1]);

  // Action bits 0/1 and the upper data bits are deliberately unused
  logic unused_bits;
  assign unused_bits = ^{bus_wdata[1:0], bus_wdata[DATA_W-1:STATUS_W],
                         tx_push_ok, tx_pop_ok, rx_pop_ok};

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_sel)
        SEL_STATUS: bus_rdata = DATA_W'(status);
        SEL_RXDATA: bus_rdata = rx_head;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assert_txspace_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && tx_count == TCW'(TXQ_DEPTH-1) && !line_tx_take) |=> !status[STB_TXSPACE]);

  assert_rx_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !rx_empty && !line_rx_strobe) |=> (rx_count == $past(rx_count) - RCW'(1)));

  assert_drop_sets_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rx_strobe && rx_full && !rd_rxd) |=> status[STB_OVRUN]);

  assert_ro_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == SEL_RXDATA && !bus_rd && !line_rx_strobe) |=> $stable(rx_count));

  assert_wo_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_sel == SEL_ACTION || bus_sel == SEL_TXDATA)) |-> (bus_rdata == '0));

endmodule

// File: tb/serdev_hostregs_test.sv
`timescale 1ns/1ps
module serdev_hostregs_test;
  localparam int DW = 8;
  localparam int TQ = 4;
  localparam int RQ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [DW-1:0] line_tx_byte;
  logic line_tx_valid;
  logic line_tx_take = 1'b0;
  logic [DW-1:0] line_rx_byte = '0;
  logic line_rx_strobe = 1'b0, line_urun_evt = 1'b0, line_ovrun_evt = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serdev_hostregs #(.DATA_W(DW), .TXQ_DEPTH(TQ), .RXQ_DEPTH(RQ)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_tx_byte(line_tx_byte),
    .line_tx_valid(line_tx_valid), .line_tx_take(line_tx_take),
    .line_rx_byte(line_rx_byte), .line_rx_strobe(line_rx_strobe),
    .line_urun_evt(line_urun_evt), .line_ovrun_evt(line_ovrun_evt));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] sel, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = sel; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [DW-1:0] b);
    @(negedge clk);
    line_rx_strobe = 1'b1; line_rx_byte = b;
    @(negedge clk);
    line_rx_strobe = 1'b0;
  endtask

  task automatic pulse_errs(input bit ur, input bit ov);
    @(negedge clk);
    line_urun_evt = ur; line_ovrun_evt = ov;
    @(negedge clk);
    line_urun_evt = 1'b0; line_ovrun_evt = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int i, input int p);
    return DW'((i * 37 + p * 11 + 5) & 8'hFF);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    bus_read(2'd0, d);
    chk("R10 status after reset", d, 8'h01);
    chk("R10 tx valid after reset", line_tx_valid, 0);

    // R1/R3 transmit fill and drain, several patterns
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < TQ + 1; i++) begin
        bus_write(2'd2, pat(i, p));
        bus_read(2'd0, d);
        chk("R1 tx space after write", d[0], (i + 1 < TQ) ? 1 : 0);
      end
      for (int i = 0; i < TQ; i++) begin
        @(negedge clk);
        #1;
        chk("R3 tx valid", line_tx_valid, 1);
        chk("R3 tx order", line_tx_byte, pat(i, p));
        line_tx_take = 1'b1;
        @(negedge clk);
        line_tx_take = 1'b0;
        bus_read(2'd0, d);
        chk("R1 tx space after take", d[0], 1);
      end
      chk("R3 extra write discarded", line_tx_valid, 0);
    end

    // R8 write-only reads return zero, even with data pending
    bus_write(2'd2, 8'hA5);
    bus_read(2'd2, d);
    chk("R8 read tx select", d, 0);
    bus_read(2'd1, d);
    chk("R8 read action select", d, 0);
    @(negedge clk); line_tx_take = 1'b1; @(negedge clk); line_tx_take = 1'b0;

    // R2/R4/R7 receive fill, overrun drop and drain
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < RQ + 1; i++) begin
        rx_push(pat(i, p + 5));
        bus_read(2'd0, d);
        chk("R2 rx data flag", d[1], 1);
        chk("R7 overrun on full", d[3], (i == RQ) ? 1 : 0);
      end
      for (int i = 0; i < RQ; i++) begin
        bus_read(2'd3, d);
        chk("R4 rx order", d, pat(i, p + 5));
        bus_read(2'd0, d);
        chk("R2 rx flag after read", d[1], (i + 1 < RQ) ? 1 : 0);
      end
      bus_read(2'd3, d);
      chk("R4 empty read zero", d, 0);
      bus_read(2'd0, d);
      chk("R4 empty read no effect", d, 8'h09);
      bus_write(2'd1, 8'h08);
      bus_read(2'd0, d);
      chk("R5 overrun cleared", d, 8'h01);
    end

    // R7 line strobes set the error bits
    pulse_errs(1'b1, 1'b0);
    bus_read(2'd0, d);
    chk("R7 underrun strobe", d, 8'h05);
    pulse_errs(1'b0, 1'b1);
    bus_read(2'd0, d);
    chk("R7 overrun strobe", d, 8'h0D);

    // R5/R9 sweep over all action values, one rx byte held, tx empty
    rx_push(8'h3C);
    for (int v = 0; v < 16; v++) begin
      pulse_errs(1'b1, 1'b1);
      bus_write(2'd1, DW'(v));
      bus_read(2'd0, d);
      chk("R5 R9 action sweep", d,
          {4'h0, ~v[3] ? 1'b1 : 1'b0, ~v[2] ? 1'b1 : 1'b0, 1'b1, 1'b1});
    end
    bus_read(2'd3, d);
    chk("R9 rx byte survives action", d, 8'h3C);
    bus_write(2'd1, 8'h0C);

    // R6 event and clear in the same cycle
    @(negedge clk);
    bus_sel = 2'd1; bus_wr = 1'b1; bus_wdata = 8'h0C;
    line_urun_evt = 1'b1; line_ovrun_evt = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; line_urun_evt = 1'b0; line_ovrun_evt = 1'b0;
    bus_read(2'd0, d);
    chk("R6 set wins over clear", d, 8'h0D);
    bus_write(2'd1, 8'h0C);
    bus_read(2'd0, d);
    chk("R6 later clear works", d, 8'h01);

    // R8 writes to read-only selects are ignored
    rx_push(8'h77);
    bus_write(2'd0, 8'hFF);
    bus_write(2'd3, 8'h12);
    bus_read(2'd0, d);
    chk("R8 ro write status", d, 8'h03);
    bus_read(2'd3, d);
    chk("R8 ro write rx data", d, 8'h77);
    bus_read(2'd0, d);
    chk("R8 ro write final", d, 8'h01);
    chk("R8 tx untouched", line_tx_valid, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule